// File: doc/BRIEF.md
# FIFO Flag Offset Register Loader

This block keeps the two threshold offsets a FIFO's programmable flag logic compares against: the almost-empty offset and the almost-full offset. While master reset is held, two select straps and a load-method strap pick one of eight default values. That value goes into both offsets at once. The load-method strap is captured at the same time. It fixes, until the next master reset, whether later writes arrive one bit at a time on a serial input or as whole words on a parallel data bus.

After reset, software-side logic may rewrite the offsets at any moment. Both offsets can be read back one after the other over a registered parallel output in either load method. The offsets drive the flag comparators directly. The FIFO storage and the comparators themselves sit outside this block.

The `DEPTH` parameter sets the offset width (log2 of depth). A depth of exactly 1024 uses the shallow default table. Larger depths use the deep table, where the strap code 100 selects the largest default (1023) and not the fifth-largest.

Top module: `flag_offset_loader`

## Requirements
- R1: While `mrst` is high, both `empty_off` and `full_off` load the same default value, keyed by {`ld_strap`,`fsel[1]`,`fsel[0]`}. For DEPTH=1024 the values are 010→511, 001→255, 000→127, 011→63, 100→31, 110→15, 101→7, 111→3. These values are visible in the first cycle after reset releases.
- R2: `ld_strap`=1 at reset selects serial loading and `ld_strap`=0 selects parallel loading. Changing `ld_strap` after reset does not change the method.
- R3: In parallel mode, each `wr_en` strobe writes `wr_data` into the offsets alternately, starting with `empty_off`, then `full_off`, then back to `empty_off`. The other offset is untouched and `ser_in` is ignored.
- R4: In serial mode, each `wr_en` strobe shifts in one bit from `ser_in`. The first 10 bits (W bits in general) form `empty_off`, least significant bit first, and the next 10 bits form `full_off`, least significant bit first. Neither offset changes until the 20th bit, when both update together. `wr_data` is ignored.
- R5: Each `rd_en` strobe presents an offset on `rd_data` one cycle later, alternating `empty_off`, `full_off`, `empty_off`, and so on. This works the same in both modes. `rd_data` holds its value between strobes.
- R6: `wr_en` and `rd_en` asserted while `mrst` is high have no effect. After reset the offsets hold their defaults and the first readback returns `empty_off`.
- R7: A parallel write, or the final serial bit, is visible on `empty_off`/`full_off` one cycle after the strobe edge. Any value from 0 to DEPTH-1 is stored exactly.
- R8: Reset clears `rd_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Master reset, synchronous, active high; straps sampled while high |
| ld_strap | input | 1 | Load-method strap: 1 serial, 0 parallel; also part of default key |
| fsel | input | 2 | Default-select straps |
| wr_en | input | 1 | Write strobe (one word in parallel mode, one bit in serial mode) |
| wr_data | input | W | Parallel write word |
| ser_in | input | 1 | Serial write bit |
| rd_en | input | 1 | Readback strobe |
| rd_data | output | W | Registered readback word |
| empty_off | output | W | Almost-empty offset to flag logic |
| full_off | output | W | Almost-full offset to flag logic |

## Verification
The bench counts when each result is due:
- **Defaults:** observable in the first cycle after `mrst` falls.
- **Writes:** a parallel write, or the last of 20 serial bits, shows up one cycle after its strobe edge.
- **Readback:** a word appears on `rd_data` one cycle after its `rd_en` edge.

The bench drives every strobe on a falling edge and samples on the next falling edge, so each check lands half a cycle after the register that produces it. For readback, the driver pushes the expected word into a queue, and a monitor pops it on the falling edge after a strobe it saw outside reset. Partial serial frames are checked at bit 19 to confirm the offsets have not moved early.

// File: rtl/flo_pkg.sv
package flo_pkg;

   typedef enum logic {
      LOAD_PAR = 1'b0,
      LOAD_SER = 1'b1
   } load_mode_e;

   // largest default table entry is always (DFLT_BASE >> rank) - 1
   localparam int DFLT_BASE = 1024;

   // rank of a strap key in the default table; code 100 moves with the variant
   function automatic int unsigned key_rank(input logic [2:0] key,
                                            input int unsigned top_rank);
      int unsigned r;
      case (key)
         3'b100:  r = top_rank;
         3'b010:  r = 1;
         3'b001:  r = 2;
         3'b000:  r = 3;
         3'b011:  r = 4;
         3'b110:  r = 6;
         3'b101:  r = 7;
         default: r = 8;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/flo_defaults.sv
module flo_defaults #(
   parameter int DEPTH = 1024,
   localparam int W = $clog2(DEPTH)
) (
   input  logic         ld_strap,
   input  logic [1:0]   fsel,
   output logic [W-1:0] dflt
);
   import flo_pkg::*;

   int unsigned rank;
   int unsigned top_rank;

   generate
      if (DEPTH > DFLT_BASE) begin : g_deep
         // deep variant: code 100 picks the largest default
         assign top_rank = 0;
      end else begin : g_shallow
         assign top_rank = 5;
      end
   endgenerate

   always_comb begin
      rank = key_rank({ld_strap, fsel}, top_rank);
      dflt = W'((DFLT_BASE >> rank) - 1);
   end

endmodule

// File: rtl/flo_par_loader.sv
module flo_par_loader (
   input  logic clk,
   input  logic mrst,
   input  logic en,
   output logic we_empty,
   output logic we_full
);
   logic to_full;

   always_ff @(posedge clk) begin
      if (mrst)    to_full <= 1'b0;
      else if (en) to_full <= ~to_full;
   end

   assign we_empty = en & ~to_full;
   assign we_full  = en &  to_full;

   // R3: target alternates on every accepted strobe
   a_r3_alternate: assert property (@(posedge clk) disable iff (mrst)
      we_empty |=> !we_empty);

endmodule

// File: rtl/flo_ser_loader.sv
module flo_ser_loader #(
   parameter int W = 10,
   localparam int FRAME = 2 * W,
   localparam int CW = $clog2(FRAME)
) (
   input  logic           clk,
   input  logic           mrst,
   input  logic           en,
   input  logic           bit_in,
   output logic           done,
   output logic [FRAME-1:0] frame
);
   logic [FRAME-1:0] shreg;
   logic [CW-1:0]    cnt;
   logic             last;

   assign last  = (cnt == CW'(FRAME - 1));
   assign done  = en & last;
   // right shift: first bit ends in bit 0, giving LSB-first, empty-first fields
   assign frame = {bit_in, shreg[FRAME-1:1]};

   always_ff @(posedge clk) begin
      if (mrst) begin
         cnt   <= '0;
         shreg <= '0;
      end else if (en) begin
         shreg <= frame;
         cnt   <= last ? '0 : cnt + 1'b1;
      end
   end

   // R4: bit counter never exceeds a frame
   a_r4_count_range: assert property (@(posedge clk) disable iff (mrst)
      en |=> (cnt <= CW'(FRAME - 1)));

endmodule

// File: rtl/flo_readback.sv
module flo_readback #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         mrst,
   input  logic         rd_en,
   input  logic [W-1:0] empty_off,
   input  logic [W-1:0] full_off,
   output logic [W-1:0] rd_data
);
   logic rptr;

   always_ff @(posedge clk) begin
      if (mrst) begin
         rptr    <= 1'b0;
         rd_data <= '0;
      end else if (rd_en) begin
         rptr    <= ~rptr;
         rd_data <= rptr ? full_off : empty_off;
      end
   end

   // R5: pointer advances per strobe, output holds otherwise
   a_r5_ptr_step: assert property (@(posedge clk) disable iff (mrst)
      rd_en |=> (rptr != $past(rptr)));
   a_r5_hold: assert property (@(posedge clk) disable iff (mrst)
      !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader #(
   parameter int DEPTH = 1024,
   localparam int W = $clog2(DEPTH)
) (
   input  logic         clk,
   input  logic         mrst,
   input  logic         ld_strap,
   input  logic [1:0]   fsel,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         ser_in,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic [W-1:0] empty_off,
   output logic [W-1:0] full_off
);
   import flo_pkg::*;

   generate
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
         $error("DEPTH must be a power of two");
      end
      if (DEPTH < DFLT_BASE) begin : g_bad_small
         $error("DEPTH must be at least 1024 to hold the defaults");
      end
   endgenerate

   load_mode_e   mode_q;
   logic [W-1:0] empty_q, full_q, dflt;
   logic         par_en, ser_en, we_empty, we_full, ser_done;
   logic [2*W-1:0] ser_frame;

   assign par_en = wr_en & ~mrst & (mode_q == LOAD_PAR);
   assign ser_en = wr_en & ~mrst & (mode_q == LOAD_SER);

   flo_defaults #(.DEPTH(DEPTH)) u_dflt (
      .ld_strap (ld_strap),
      .fsel     (fsel),
      .dflt     (dflt)
   );

   flo_par_loader u_par (
      .clk      (clk),
      .mrst     (mrst),
      .en       (par_en),
      .we_empty (we_empty),
      .we_full  (we_full)
   );

   flo_ser_loader #(.W(W)) u_ser (
      .clk    (clk),
      .mrst   (mrst),
      .en     (ser_en),
      .bit_in (ser_in),
      .done   (ser_done),
      .frame  (ser_frame)
   );

   always_ff @(posedge clk) begin
      if (mrst) begin
         mode_q  <= load_mode_e'(ld_strap);
         empty_q <= dflt;
         full_q  <= dflt;
      end else if (ser_done) begin
         empty_q <= ser_frame[W-1:0];
         full_q  <= ser_frame[2*W-1:W];
      end else begin
         if (we_empty) empty_q <= wr_data;
         if (we_full)  full_q  <= wr_data;
      end
   end

   flo_readback #(.W(W)) u_rb (
      .clk       (clk),
      .mrst      (mrst),
      .rd_en     (rd_en),
      .empty_off (empty_q),
      .full_off  (full_q),
      .rd_data   (rd_data)
   );

   assign empty_off = empty_q;
   assign full_off  = full_q;

   // R1: both offsets leave reset equal
   a_r1_same_default: assert property (@(posedge clk) disable iff (mrst)
      $fell(mrst) |-> (empty_q == full_q));
   // R2: method fixed between resets
   a_r2_mode_held: assert property (@(posedge clk) disable iff (mrst)
      !mrst |=> $stable(mode_q));
   // R4: partial serial frame leaves offsets alone
   a_r4_hold_partial: assert property (@(posedge clk) disable iff (mrst)
      (mode_q == LOAD_SER && !ser_done) |=> ($stable(empty_q) && $stable(full_q)));
   // R3: parallel write to empty leaves full alone
   a_r3_par_empty: assert property (@(posedge clk) disable iff (mrst)
      (mode_q == LOAD_PAR && we_empty) |=> (empty_q == $past(wr_data) && $stable(full_q)));

endmodule

// File: tb/test_flag_offset_loader.sv
module test_flag_offset_loader;
   localparam int DEPTH = 1024;
   localparam int W = 10;

   logic         clk = 1'b0;
   logic         mrst = 1'b1;
   logic         ld_strap = 1'b0;
   logic [1:0]   fsel = 2'b00;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         ser_in = 1'b0;
   logic         rd_en = 1'b0;
   logic [W-1:0] rd_data, empty_off, full_off;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // bench model
   int  m_n, m_m, m_cnt;
   bit  m_ser, m_wp, m_rp;
   logic [2*W-1:0] m_sh;
   int  expq[$];
   bit  rd_seen = 0;

   always #4 clk = ~clk;   // 125 MHz

   flag_offset_loader #(.DEPTH(DEPTH)) i_flag_offset_loader (
      .clk(clk), .mrst(mrst), .ld_strap(ld_strap), .fsel(fsel),
      .wr_en(wr_en), .wr_data(wr_data), .ser_in(ser_in), .rd_en(rd_en),
      .rd_data(rd_data), .empty_off(empty_off), .full_off(full_off)
   );

   function automatic int dflt(input bit [2:0] k);
      case (k)
         3'b010: return 511;
         3'b001: return 255;
         3'b000: return 127;
         3'b011: return 63;
         3'b100: return 31;
         3'b110: return 15;
         3'b101: return 7;
         default: return 3;
      endcase
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // monitor: readback words due one cycle after an accepted strobe
   always @(posedge clk) rd_seen <= rd_en && !mrst;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (expq.size() == 0) chk("R5 unexpected readback", int'(rd_data), -1);
         else chk("R5 readback word", int'(rd_data), expq.pop_front());
      end
   end

   task automatic do_reset(input bit ld, input bit [1:0] fs);
      mrst = 1'b1; ld_strap = ld; fsel = fs;
      @(negedge clk); @(negedge clk);
      mrst = 1'b0;
      m_n = dflt({ld, fs}); m_m = m_n; m_ser = ld;
      m_wp = 0; m_rp = 0; m_cnt = 0; m_sh = '0;
   endtask

   task automatic wr_word(input int v);
      wr_en = 1'b1; wr_data = W'(v); ser_in = ~ser_in;
      @(negedge clk);
      wr_en = 1'b0;
      if (!m_ser) begin
         if (!m_wp) m_n = v; else m_m = v;
         m_wp = !m_wp;
      end else m_cnt++;
   endtask

   task automatic wr_bit(input bit b);
      wr_en = 1'b1; ser_in = b; wr_data = ~wr_data;
      @(negedge clk);
      wr_en = 1'b0;
      m_sh = {b, m_sh[2*W-1:1]};
      m_cnt++;
      if (m_cnt == 2*W) begin
         m_n = int'(m_sh[W-1:0]); m_m = int'(m_sh[2*W-1:W]); m_cnt = 0;
      end
   endtask

   task automatic rd_word();
      rd_en = 1'b1;
      expq.push_back(m_rp ? m_m : m_n);
      m_rp = !m_rp;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      // R1/R2/R8: every strap key, then one word strobe
      for (int k = 0; k < 8; k++) begin
         do_reset(k[2], k[1:0]);
         chk("R1 empty default", int'(empty_off), m_n);
         chk("R1 full default", int'(full_off), m_m);
         chk("R8 rd_data reset", int'(rd_data), 0);
         wr_word(10'h155);
         chk("R2 method from strap", int'(empty_off), m_n);
      end

      // R6: strobes during reset ignored
      mrst = 1'b1; ld_strap = 1'b0; fsel = 2'b10;
      @(negedge clk);
      wr_en = 1'b1; wr_data = 10'h3C3; rd_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      @(negedge clk);
      mrst = 1'b0;
      m_n = 511; m_m = 511; m_ser = 0; m_wp = 0; m_rp = 0;
      chk("R6 empty after strobed reset", int'(empty_off), 511);
      chk("R6 full after strobed reset", int'(full_off), 511);
      rd_word();   // R6: first read is the empty offset

      // R3/R7: parallel alternation with wrap, strap change ignored (R2)
      ld_strap = 1'b1;
      wr_word(100);
      chk("R3 empty written", int'(empty_off), 100);
      chk("R3 full untouched", int'(full_off), 511);
      wr_word(200);
      chk("R3 full written", int'(full_off), 200);
      chk("R7 empty kept", int'(empty_off), 100);
      wr_word(300);
      chk("R3 wrap to empty", int'(empty_off), 300);
      chk("R2 still parallel full", int'(full_off), 200);
      rd_word(); rd_word(); rd_word();   // R5 alternation

      // R7 boundary values 0 and DEPTH-1
      wr_word(0);      // goes to full (pointer at full)
      wr_word(1023);   // empty
      chk("R7 full zero", int'(full_off), 0);
      chk("R7 empty max", int'(empty_off), 1023);
      rd_word(); rd_word();

      // R4: serial frame, empty 0x2A5 then full 0x15A, LSB first
      do_reset(1'b1, 2'b11);
      ld_strap = 1'b0;
      for (int i = 0; i < W; i++) wr_bit(1'((10'h2A5 >> i) & 1));
      for (int i = 0; i < W - 1; i++) wr_bit(1'((10'h15A >> i) & 1));
      chk("R4 empty held mid-frame", int'(empty_off), 3);
      chk("R4 full held mid-frame", int'(full_off), 3);
      wr_bit(1'((10'h15A >> (W - 1)) & 1));
      chk("R4 empty from frame", int'(empty_off), 'h2A5);
      chk("R4 full from frame", int'(full_off), 'h15A);
      rd_word(); rd_word();   // R5 in serial mode

      @(negedge clk); @(negedge clk);
      chk("R5 queue drained", expq.size(), 0);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule